// File: doc/BRIEF.md
# Sync-Burst Serializer

This block turns a stream of 10-bit parallel words into a serial bit stream at ten times the word rate. It runs on one fast clock. A bit-rate clock enable, `bit_ce`, marks each serial bit slot, and every tenth enabled cycle is a symbol boundary. Words arrive with a slower word clock, `word_clk`, which is sampled as a level. An edge-select input picks whether a word is captured on the rise or on the fall of that clock.

A synchronization request on either of two request inputs makes the block send training symbols instead of data, so that a far-end deserializer can lock. A burst always contains at least 1024 symbols and cannot be cut short. The burst goes on for as long as a request stays high after that minimum. The block changes between training and data only at a symbol boundary, so no symbol is ever truncated.

Two controls can silence the line. Output enable only masks the serial line. Power-down also clears every register in the block. The high-impedance state of a differential driver is modelled as a deasserted valid flag.

Top module: `sync_burst_serializer`

## Requirements
- R1: With `edge_sel` high, `din` is registered on the clock cycle where a 0-to-1 change of `word_clk` is first seen. The value present at the 1-to-0 change is not used.
- R2: With `edge_sel` low, `din` is registered where a 1-to-0 change of `word_clk` is first seen. The value present at the 0-to-1 change is not used.
- R3: The register stage that drives the line advances one bit on each cycle with `bit_ce` high. A symbol is 10 bits, sent bit 0 first. With `bit_ce` low, `sdo` holds its value.
- R4: `sync_a` and `sync_b` are ORed. A request of any length, even one clock, produces exactly 1024 back-to-back training symbols if it is gone before the 1024th of them.
- R5: While the request is still high at a boundary after the first 1024 training symbols, another training symbol is sent. The burst length then equals the number of boundaries at which the request was high.
- R6: A training symbol is the 10-bit value 0x01F: bits 0 to 4 are one and bits 5 to 9 are zero. On the line this is five ones followed by five zeros.
- R7: Training and data alternate only at symbol boundaries. Each data symbol is the most recently captured word at its boundary.
- R8: A request that arrives after a burst has ended starts a fresh burst of the full minimum length. A request pulse that starts and ends within a running burst does not extend it.
- R9: With `oe` low and `pwr_n` high, `sdo_vld` and `sdo` are 0 while shifting continues. The words whose symbols fall inside the masked window are lost, and the stream resumes in order.
- R10: With `pwr_n` low, `sdo_vld` is 0 whatever the other inputs are. Power-down synchronously clears the captured word, the shifter and the burst state. The block operates only while `pwr_n` is driven high. After release, the first symbol is the cleared word 0, unless a request is present.
- R11: `sdo_vld` is high only with `pwr_n` high, `oe` high, and at least one symbol loaded since reset or power-down. It is 0 during `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_n | input | 1 | Power-down, active low; clears all state |
| oe | input | 1 | Serial output enable, active high |
| bit_ce | input | 1 | Bit-slot enable |
| word_clk | input | 1 | Word clock, sampled as a level |
| edge_sel | input | 1 | 1 selects capture on the rise of `word_clk`, 0 on the fall |
| din | input | SYM_W | Parallel data word |
| sync_a | input | 1 | Synchronization request, first input |
| sync_b | input | 1 | Synchronization request, second input |
| sdo | output | 1 | Serial data, 0 when not valid |
| sdo_vld | output | 1 | Line driven (low models high impedance) |

## Verification
A fault in the burst counter shows up as a training run of the wrong length. It is visible at the first data symbol after the burst, at most 1025 symbol times after the request. A shifter index that is out of step misframes every symbol from the next boundary on. Every deserialized word then fails to match within ten cycles. A bad capture-edge decode loads the decoy value placed on `din` at the other edge, so the error appears one symbol later. Leftover state after power-down shows in the first symbol after release, which must be 0.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    BURST_IDLE,
    BURST_MIN,
    BURST_HOLD
  } burst_state_e;

  // Training pattern: lower half of the symbol set, upper half clear.
  function automatic logic [31:0] sync_pattern(input int unsigned width);
    logic [31:0] pat;
    pat = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      pat[i] = (i < (width / 2));
    end
    return pat;
  endfunction

  // Edge detection on a sampled level, rising or falling by selection.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/sbs_capture.sv
module sbs_capture #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         word_clk,
  input  logic         edge_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q
);

  logic wclk_q;
  logic cap_evt;

  assign cap_evt = sbs_pkg::edge_hit(word_clk, wclk_q, edge_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q <= 1'b0;
      word_q <= '0;
    end else if (clr) begin
      wclk_q <= 1'b0;
      word_q <= '0;
    end else begin
      wclk_q <= word_clk;
      if (cap_evt) word_q <= din;
    end
  end

  // R1 / R2: a capture event loads the input word
  a_r1_capture_loads: assert property (@(posedge clk) disable iff (!rst_n || clr)
    cap_evt |=> (word_q == $past(din)));

  // R2: without a capture event the word is untouched
  a_r2_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !cap_evt |=> $stable(word_q));

endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl #(
  parameter int unsigned MIN_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req_a,
  input  logic req_b,
  input  logic sym_bound,
  output logic send_sync
);
  import sbs_pkg::*;

  localparam int unsigned CNT_W = $clog2(MIN_LEN) + 1;
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);

  logic             req;
  logic             pend_q;
  logic [CNT_W-1:0] sent_cnt;
  burst_state_e     state;
  logic             min_done;

  assign req      = req_a | req_b;
  assign min_done = (sent_cnt == MIN_CNT);

  always_comb begin
    unique case (state)
      BURST_IDLE: send_sync = req | pend_q;
      BURST_MIN:  send_sync = !min_done || req;
      BURST_HOLD: send_sync = req;
      default:    send_sync = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= BURST_IDLE;
      sent_cnt <= '0;
      pend_q   <= 1'b0;
    end else if (clr) begin
      state    <= BURST_IDLE;
      sent_cnt <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (sym_bound) pend_q <= 1'b0;
      else if (req)  pend_q <= 1'b1;
      if (sym_bound) begin
        unique case (state)
          BURST_IDLE: if (send_sync) begin
            state    <= BURST_MIN;
            sent_cnt <= CNT_W'(1);
          end
          BURST_MIN: if (!min_done) begin
            sent_cnt <= sent_cnt + CNT_W'(1);
          end else if (req) begin
            state <= BURST_HOLD;
          end else begin
            state    <= BURST_IDLE;
            sent_cnt <= '0;
          end
          BURST_HOLD: if (!req) begin
            state    <= BURST_IDLE;
            sent_cnt <= '0;
          end
          default: state <= BURST_IDLE;
        endcase
      end
    end
  end

  // R4: the count never passes the minimum
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sent_cnt <= MIN_CNT);

  // R4: each training symbol of the minimum phase advances the count
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (sym_bound && state == BURST_MIN && !min_done) |=> (sent_cnt == $past(sent_cnt) + CNT_W'(1)));

  // R8: a new burst starts counting from one
  a_r8_fresh_start: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (sym_bound && state == BURST_IDLE && send_sync) |=> (sent_cnt == CNT_W'(1) && state == BURST_MIN));

  // R10: power-down leaves the burst idle and empty
  a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == BURST_IDLE && sent_cnt == '0 && !pend_q));

endmodule

// File: rtl/sbs_shifter.sv
module sbs_shifter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_ce,
  input  logic [W-1:0] next_sym,
  output logic         sym_bound,
  output logic         raw_bit,
  output logic         loaded
);

  localparam int unsigned IDX_W = $clog2(W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(W - 1);

  logic [IDX_W-1:0] idx;
  logic [W-1:0]     sh;

  assign sym_bound = bit_ce && (idx == LAST) && !clr;
  assign raw_bit   = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= LAST;
      sh     <= '0;
      loaded <= 1'b0;
    end else if (clr) begin
      idx    <= LAST;
      sh     <= '0;
      loaded <= 1'b0;
    end else if (bit_ce) begin
      if (idx == LAST) begin
        sh     <= next_sym;
        idx    <= '0;
        loaded <= 1'b1;
      end else begin
        sh  <= sh >> 1;
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R3: a boundary restarts the bit index
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n || clr)
    sym_bound |=> (idx == '0));

  // R3: no enable, no movement
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !bit_ce |=> ($stable(sh) && $stable(idx)));

  // R3: inside a symbol the next bit comes from the next-higher position
  a_r3_lsb_order: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (bit_ce && idx != LAST) |=> (raw_bit == $past(sh[1])));

endmodule

// File: rtl/sync_burst_serializer.sv
module sync_burst_serializer #(
  parameter int unsigned SYM_W    = 10,
  parameter int unsigned MIN_SYNC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic             oe,
  input  logic             bit_ce,
  input  logic             word_clk,
  input  logic             edge_sel,
  input  logic [SYM_W-1:0] din,
  input  logic             sync_a,
  input  logic             sync_b,
  output logic             sdo,
  output logic             sdo_vld
);

  localparam logic [SYM_W-1:0] SYNC_WORD = SYM_W'(sbs_pkg::sync_pattern(SYM_W));

  logic             clr;
  logic [SYM_W-1:0] word_q;
  logic [SYM_W-1:0] next_sym;
  logic             send_sync;
  logic             sym_bound;
  logic             raw_bit;
  logic             loaded;

  assign clr = ~pwr_n;

  sbs_capture #(.W(SYM_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .word_clk (word_clk),
    .edge_sel (edge_sel),
    .din      (din),
    .word_q   (word_q)
  );

  sbs_burst_ctrl #(.MIN_LEN(MIN_SYNC)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .req_a     (sync_a),
    .req_b     (sync_b),
    .sym_bound (sym_bound),
    .send_sync (send_sync)
  );

  assign next_sym = send_sync ? SYNC_WORD : word_q;

  sbs_shifter #(.W(SYM_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .bit_ce    (bit_ce),
    .next_sym  (next_sym),
    .sym_bound (sym_bound),
    .raw_bit   (raw_bit),
    .loaded    (loaded)
  );

  assign sdo_vld = pwr_n & oe & loaded;
  assign sdo     = sdo_vld & raw_bit;

  // R6: a training symbol opens with a one on the line
  a_r6_sync_lead: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (sym_bound && send_sync) |=> (raw_bit == 1'b1));

  // R7: a data symbol opens with bit 0 of the captured word
  a_r7_data_load: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (sym_bound && !send_sync) |=> (raw_bit == $past(word_q[0])));

endmodule

// File: tb/sync_burst_serializer_tb.sv
module sync_burst_serializer_tb;

  localparam time CLK_P = 8ns;
  localparam logic [9:0] TRAIN = 10'h01F;

  logic       clk = 1'b0;
  logic       rst_n, pwr_n, oe, bit_ce, word_clk, edge_sel, sync_a, sync_b;
  logic [9:0] din;
  logic       sdo, sdo_vld;

  int         nchk = 0;
  int         nerr = 0;
  bit         mon_en = 1'b0;
  bit         fin = 1'b0;
  string      cur_req = "R1";
  logic [9:0] exp_q[$];
  logic [9:0] acc;
  int         nbit = 0;
  int         run = 0;
  int         last_run = 0;

  always #(CLK_P / 2) clk = ~clk;

  sync_burst_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .oe(oe), .bit_ce(bit_ce),
    .word_clk(word_clk), .edge_sel(edge_sel), .din(din),
    .sync_a(sync_a), .sync_b(sync_b), .sdo(sdo), .sdo_vld(sdo_vld)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [9:0] wgen(input int j);
    logic [9:0] v;
    v = 10'(j * 37 + 341);
    if (v == TRAIN) v = 10'h2A5;
    return v;
  endfunction

  // Monitor: deserializes the line and scores each symbol
  always @(negedge clk) begin
    if (!mon_en) begin
      nbit = 0;
      run  = 0;
    end else if (sdo_vld) begin
      acc[nbit] = sdo;
      nbit++;
      if (nbit == 10) begin
        nbit = 0;
        if (acc == TRAIN) run++;
        else begin
          if (run != 0) begin
            last_run = run;
            run = 0;
          end
          if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected data symbol", int'(acc), -1);
          else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            chk(acc == e, cur_req, "data symbol", int'(acc), int'(e));
          end
        end
      end
    end else begin
      nbit = 0;
    end
  end

  // Driver: one word slot is ten clocks, active edge first, decoy on the other edge
  task automatic slot(input logic [9:0] w, input bit expv, input bit oe_v, input bit pulse, input bit drop);
    word_clk = edge_sel;
    din = w;
    if (pulse) begin
      sync_a = 1'b1;
      @(negedge clk);
      sync_a = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      repeat (5) @(negedge clk);
    end
    #1;
    oe = oe_v;
    word_clk = ~edge_sel;
    din = ~w;
    if (drop) sync_b = 1'b0;
    if (expv && oe_v) exp_q.push_back(w);
    repeat (5) @(negedge clk);
    if (!oe_v) begin
      chk(sdo_vld == 1'b0, "R9", "valid while disabled", int'(sdo_vld), 0);
      chk(sdo == 1'b0, "R9", "line while disabled", int'(sdo), 0);
    end
  endtask

  task automatic start_run(input bit e, input bit hold, input bit pulse, input string req);
    @(negedge clk);
    pwr_n = 1'b0;
    oe = 1'b1;
    repeat (3) @(negedge clk);
    edge_sel = e;
    word_clk = ~e;
    din = '0;
    exp_q.delete();
    last_run = 0;
    cur_req = req;
    @(negedge clk);
    pwr_n = 1'b1;
    mon_en = 1'b1;
    sync_b = hold;
    sync_a = pulse;
    if (!hold && !pulse) exp_q.push_back(10'h000); // R10: cleared word leads
    @(negedge clk);
    sync_a = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_run();
    repeat (5) @(negedge clk);
    #2;
    mon_en = 1'b0;
    chk(exp_q.size() == 0, cur_req, "words never seen", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!fin) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_n = 1'b0; oe = 1'b0; bit_ce = 1'b1;
    word_clk = 1'b0; edge_sel = 1'b1; din = '0; sync_a = 1'b0; sync_b = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdo_vld == 1'b0, "R11", "valid in reset", int'(sdo_vld), 0);
    chk(sdo == 1'b0, "R11", "line in reset", int'(sdo), 0);
    rst_n = 1'b1;
    oe = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo_vld == 1'b0, "R10", "valid in power-down", int'(sdo_vld), 0);

    // Run A: rising capture, masked window over slots 8 and 9 (R1, R3, R9)
    start_run(1'b1, 1'b0, 1'b0, "R1");
    for (int j = 0; j < 24; j++) slot(wgen(j), 1'b1, !(j == 8 || j == 9), 1'b0, 1'b0);
    end_run();

    // R3: bit enable low freezes the line
    begin
      logic s0;
      @(negedge clk);
      bit_ce = 1'b0;
      #1 s0 = sdo;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(sdo == s0, "R3", "line moved without enable", int'(sdo), int'(s0));
      end
      bit_ce = 1'b1;
    end

    // R9 / R10 / R11: enable and power-down combinations
    @(negedge clk);
    oe = 1'b0; #1;
    chk(sdo_vld == 1'b0, "R9", "valid with oe low", int'(sdo_vld), 0);
    oe = 1'b1; #1;
    chk(sdo_vld == 1'b1, "R11", "valid with both enabled", int'(sdo_vld), 1);
    pwr_n = 1'b0; #1;
    chk(sdo_vld == 1'b0, "R10", "valid in power-down, oe high", int'(sdo_vld), 0);
    oe = 1'b0; #1;
    chk(sdo_vld == 1'b0, "R10", "valid in power-down, oe low", int'(sdo_vld), 0);

    // Run B: burst cut by power-down, no data may appear (R10)
    start_run(1'b1, 1'b0, 1'b1, "R10");
    for (int j = 0; j < 50; j++) slot(wgen(j), 1'b0, 1'b1, 1'b0, 1'b0);
    end_run();

    // Run C: falling capture; leading zero shows cleared state (R2, R10)
    start_run(1'b0, 1'b0, 1'b0, "R2");
    for (int j = 0; j < 20; j++) slot(wgen(j + 100), 1'b1, 1'b1, 1'b0, 1'b0);
    end_run();

    // Run D: one-clock request gives exactly the minimum burst (R4, R6, R7)
    start_run(1'b1, 1'b0, 1'b1, "R7");
    for (int j = 0; j < 1030; j++) slot(wgen(j), j >= 1023, 1'b1, 1'b0, 1'b0);
    end_run();
    chk(last_run == 1024, "R4", "R6 training run length after short request", last_run, 1024);

    // Run E: held request (R5), then reload and absorbed pulse (R8)
    start_run(1'b1, 1'b1, 1'b0, "R7");
    for (int j = 0; j < 2241; j++) begin
      slot(wgen(j), (j >= 1199 && j < 1210) || (j >= 2234), 1'b1, (j == 1210) || (j == 1710), j == 1199);
      if (j == 1205) chk(last_run == 1200, "R5", "training run length while held", last_run, 1200);
    end
    end_run();
    chk(last_run == 1024, "R8", "fresh burst length with absorbed pulse", last_run, 1024);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule